// File: doc/BRIEF.md
# HDLC Event Status Register with Clear-on-Read

This block collects single-cycle event pulses from an HDLC receiver, an HDLC transmitter and their two FIFOs, and holds each event in its own sticky bit of an 8-bit status word. The host reads the word through a one-cycle read strobe. The word is available combinationally on `rd_data` during that cycle, and every bit clears at the clock edge that ends the read. An event that arrives in the same cycle as the read is kept, so no event is lost across a read. An active-high interrupt line stays asserted while any bit is set.

Bit 2 is shared between two events. A select input decides whether it reports a frame abort seen by the receiver or a transmitter attempt to pull from an empty TX FIFO. A received abort only counts if enough bits of the current packet have arrived. For that purpose, the block counts receiver bit strobes from the most recent opening flag, and the counter saturates at a parameterised threshold (26 by default).

Top module: `hdlc_irq_status`

## Requirements
- R1: An event pulse sets its bit at the next clock edge. The bit layout from bit 7 down to bit 0 is: go-ahead, receive end-of-packet written, transmit end-of-packet, end-of-packet read, TX FIFO low, abort/underrun (shared), RX FIFO full, RX FIFO overflow.
- R2: While `rd_stb` is high, `rd_data` shows the current register value. At the edge that ends that cycle, every bit with no event pending clears.
- R3: A set bit stays set until a read, whatever the event inputs do in the meantime.
- R4: A bit whose event pulses in the same cycle as `rd_stb` is still set after the read.
- R5: With `shared_sel` low, bit 2 is set by a qualified receive abort, and `ev_tx_underrun` has no effect on it.
- R6: With `shared_sel` high, bit 2 is set by `ev_tx_underrun`, and `ev_rx_abort` has no effect on it.
- R7: A receive abort is qualified only when at least 26 receiver bit strobes have been counted since the last opening flag. An abort that arrives after 25 or fewer strobes is ignored.
- R8: The bit counter returns to zero in the cycle after `rx_open_flag` and saturates at 26. Without a strobe or an opening flag it holds its value.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: After reset, all bits are clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_go_ahead | input | 1 | Receiver saw a go-ahead pattern |
| ev_rx_eop | input | 1 | End-of-packet byte written into RX FIFO |
| ev_tx_eop | input | 1 | Transmitter finished the closing flag or aborted a packet |
| ev_eop_read | input | 1 | Next RX FIFO byte ends a packet, or a read was made from an empty RX FIFO |
| ev_tx_low | input | 1 | TX FIFO fell below its low threshold |
| ev_rx_abort | input | 1 | Abort sequence received during a packet |
| ev_tx_underrun | input | 1 | Transmitter read from an empty TX FIFO |
| ev_rx_full | input | 1 | RX FIFO rose above its full threshold |
| ev_rx_ovf | input | 1 | Write attempted into a full RX FIFO |
| rx_open_flag | input | 1 | Receiver saw the opening flag of a packet |
| rx_bit_valid | input | 1 | One packet bit received this cycle |
| shared_sel | input | 1 | 0: bit 2 reports aborts; 1: bit 2 reports underruns |
| rd_stb | input | 1 | Host read of the status register |
| rd_data | output | 8 | Current status value |
| irq | output | 1 | High while any status bit is set |

## Verification
On every cycle, the assertions check the per-bit set, hold and clear-on-read rules. They also check that the abort-qualification counter resets, holds and saturates correctly, and that the unselected source of the shared bit and early aborts never reach the register. Only the bench scenarios show the following: the actual bit positions seen by a reader, the exact 25-versus-26 strobe boundary, the survival of an event that collides with a read, and the interrupt line following the register through whole read sequences.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
   localparam int STAT_W      = 8;
   localparam int B_GO_AHEAD  = 7;
   localparam int B_RX_EOP    = 6;
   localparam int B_TX_EOP    = 5;
   localparam int B_EOP_READ  = 4;
   localparam int B_TX_LOW    = 3;
   localparam int B_SHARED    = 2;
   localparam int B_RX_FULL   = 1;
   localparam int B_RX_OVF    = 0;
   typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/hdlc_rx_bit_counter.sv
module hdlc_rx_bit_counter #(
   parameter int MIN_BITS = 26
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_flag,
   input  logic bit_valid,
   output logic enough_bits
);
   localparam int CNT_W = $clog2(MIN_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BITS);

   initial begin
      if (MIN_BITS < 1) $error("MIN_BITS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (open_flag)
         cnt_q <= '0;
      else if (bit_valid && (cnt_q != CNT_MAX))
         cnt_q <= cnt_q + 1'b1;
   end

   assign enough_bits = (cnt_q == CNT_MAX);

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      open_flag |=> (cnt_q == '0)); // R8
   AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_flag && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R8
   AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_flag && !bit_valid) |=> $stable(cnt_q)); // R8
   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q <= CNT_MAX)); // R8
endmodule

// File: rtl/hdlc_shared_event_sel.sv
module hdlc_shared_event_sel #(
   parameter bit QUALIFY_ABORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic rx_abort,
   input  logic abort_ok,
   input  logic tx_underrun,
   output logic shared_ev
);
   logic rx_term;

   generate
      if (QUALIFY_ABORT) begin : g_qual
         assign rx_term = rx_abort & abort_ok;
      end else begin : g_raw
         assign rx_term = rx_abort;
      end
   endgenerate

   assign shared_ev = sel ? tx_underrun : rx_term;

   AST_UNDERRUN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !rx_abort) |-> !shared_ev); // R5
   AST_ABORT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !tx_underrun) |-> !shared_ev); // R6
   generate
      if (QUALIFY_ABORT) begin : g_chk
         AST_EARLY_ABORT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel && !abort_ok) |-> !shared_ev); // R7
      end
   endgenerate
endmodule

// File: rtl/hdlc_sticky_bank.sv
module hdlc_sticky_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr,
   output logic [W-1:0] q
);
   initial begin
      if (W < 1) $error("W must be at least 1");
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= 1'b0;
            else
               q[i] <= (q[i] & ~clr) | set_vec[i];
         end

         AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> q[i]); // R1
         AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set_vec[i]) |=> !q[i]); // R2
         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && q[i]) |=> q[i]); // R3
         AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && set_vec[i]) |=> q[i]); // R4
      end
   endgenerate
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
   import hdlc_irq_pkg::*;
#(
   parameter int MIN_ABORT_BITS = 26,
   parameter bit QUALIFY_ABORT  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ev_go_ahead,
   input  logic        ev_rx_eop,
   input  logic        ev_tx_eop,
   input  logic        ev_eop_read,
   input  logic        ev_tx_low,
   input  logic        ev_rx_abort,
   input  logic        ev_tx_underrun,
   input  logic        ev_rx_full,
   input  logic        ev_rx_ovf,
   input  logic        rx_open_flag,
   input  logic        rx_bit_valid,
   input  logic        shared_sel,
   input  logic        rd_stb,
   output logic [7:0]  rd_data,
   output logic        irq
);
   initial begin
      if (STAT_W != 8) $error("status word must be 8 bits");
   end

   logic  abort_ok;
   logic  shared_ev;
   stat_t set_vec;
   stat_t stat_q;

   hdlc_rx_bit_counter #(.MIN_BITS(MIN_ABORT_BITS)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .open_flag(rx_open_flag), .bit_valid(rx_bit_valid),
      .enough_bits(abort_ok)
   );

   hdlc_shared_event_sel #(.QUALIFY_ABORT(QUALIFY_ABORT)) u_sel (
      .clk(clk), .rst_n(rst_n), .sel(shared_sel),
      .rx_abort(ev_rx_abort), .abort_ok(abort_ok),
      .tx_underrun(ev_tx_underrun), .shared_ev(shared_ev)
   );

   always_comb begin
      set_vec             = '0;
      set_vec[B_GO_AHEAD] = ev_go_ahead;
      set_vec[B_RX_EOP]   = ev_rx_eop;
      set_vec[B_TX_EOP]   = ev_tx_eop;
      set_vec[B_EOP_READ] = ev_eop_read;
      set_vec[B_TX_LOW]   = ev_tx_low;
      set_vec[B_SHARED]   = shared_ev;
      set_vec[B_RX_FULL]  = ev_rx_full;
      set_vec[B_RX_OVF]   = ev_rx_ovf;
   end

   hdlc_sticky_bank #(.W(STAT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(rd_stb), .q(stat_q)
   );

   assign rd_data = stat_q;
   assign irq     = |stat_q;

   AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> irq); // R9
   AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && set_vec == '0) |=> !irq); // R9
endmodule

// File: tb/sim_hdlc_irq_status.sv
module sim_hdlc_irq_status;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_go_ahead = 0, ev_rx_eop = 0, ev_tx_eop = 0, ev_eop_read = 0;
   logic ev_tx_low = 0, ev_rx_abort = 0, ev_tx_underrun = 0, ev_rx_full = 0;
   logic ev_rx_ovf = 0, rx_open_flag = 0, rx_bit_valid = 0, shared_sel = 0, rd_stb = 0;
   logic [7:0] rd_data;
   logic irq;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   hdlc_irq_status u0 (
      .clk(clk), .rst_n(rst_n), .ev_go_ahead(ev_go_ahead), .ev_rx_eop(ev_rx_eop),
      .ev_tx_eop(ev_tx_eop), .ev_eop_read(ev_eop_read), .ev_tx_low(ev_tx_low),
      .ev_rx_abort(ev_rx_abort), .ev_tx_underrun(ev_tx_underrun),
      .ev_rx_full(ev_rx_full), .ev_rx_ovf(ev_rx_ovf), .rx_open_flag(rx_open_flag),
      .rx_bit_valid(rx_bit_valid), .shared_sel(shared_sel), .rd_stb(rd_stb),
      .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Drive the eight event lines for one cycle; bit order matches R1 layout.
   task automatic pulse(input logic [7:0] ev, input logic with_rd);
      {ev_go_ahead, ev_rx_eop, ev_tx_eop, ev_eop_read, ev_tx_low} = ev[7:3];
      ev_rx_abort    = ev[2] & ~shared_sel;
      ev_tx_underrun = ev[2] &  shared_sel;
      {ev_rx_full, ev_rx_ovf} = ev[1:0];
      rd_stb = with_rd;
      @(negedge clk);
      {ev_go_ahead, ev_rx_eop, ev_tx_eop, ev_eop_read, ev_tx_low} = '0;
      {ev_rx_abort, ev_tx_underrun, ev_rx_full, ev_rx_ovf, rd_stb} = '0;
   endtask

   task automatic do_read(output logic [7:0] val);
      rd_stb = 1'b1;
      #1 val = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic feed_bits(input int n);
      for (int k = 0; k < n; k++) begin
         rx_bit_valid = 1'b1;
         @(negedge clk);
      end
      rx_bit_valid = 1'b0;
   endtask

   task automatic open_packet();
      rx_open_flag = 1'b1;
      @(negedge clk);
      rx_open_flag = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 reset value", rd_data, 8'h00);
      chk("R10 irq after reset", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_layout();
      logic [7:0] v;
      for (int b = 7; b >= 0; b--) begin
         if (b == 2) continue;
         pulse(8'h01 << b, 1'b0);
         chk("R1 single bit position", rd_data, 8'h01 << b);
         chk("R9 irq with one bit", {7'b0, irq}, 8'h01);
         do_read(v);
         chk("R2 read value", v, 8'h01 << b);
         chk("R2 cleared after read", rd_data, 8'h00);
         chk("R9 irq low after read", {7'b0, irq}, 8'h00);
      end
   endtask

   task automatic t_sticky();
      logic [7:0] v;
      pulse(8'hA2, 1'b0);
      pulse(8'h00, 1'b0);
      pulse(8'h41, 1'b0);
      repeat (3) @(negedge clk);
      chk("R3 bits accumulate and hold", rd_data, 8'hE3);
      do_read(v);
      chk("R2 read returns accumulated", v, 8'hE3);
      chk("R2 all clear", rd_data, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      pulse(8'h18, 1'b0);
      pulse(8'h81, 1'b1);
      chk("R4 event during read survives", rd_data, 8'h81);
      do_read(v);
      chk("R4 follow-up read", v, 8'h81);
   endtask

   task automatic t_abort_boundary();
      logic [7:0] v;
      shared_sel = 1'b0;
      open_packet();
      feed_bits(25);
      pulse(8'h04, 1'b0);
      chk("R7 abort after 25 bits ignored", rd_data, 8'h00);
      feed_bits(1);
      pulse(8'h04, 1'b0);
      chk("R7 abort after 26 bits sets bit 2", rd_data, 8'h04);
      do_read(v);
      feed_bits(40);
      pulse(8'h04, 1'b0);
      chk("R8 counter saturates, abort still qualified", rd_data, 8'h04);
      do_read(v);
      open_packet();
      pulse(8'h04, 1'b0);
      chk("R8 opening flag restarts count", rd_data, 8'h00);
   endtask

   task automatic t_shared_select();
      logic [7:0] v;
      shared_sel = 1'b0;
      ev_tx_underrun = 1'b1;
      @(negedge clk);
      ev_tx_underrun = 1'b0;
      chk("R5 underrun ignored with select low", rd_data, 8'h00);
      shared_sel = 1'b1;
      open_packet();
      feed_bits(30);
      ev_rx_abort = 1'b1;
      @(negedge clk);
      ev_rx_abort = 1'b0;
      chk("R6 abort ignored with select high", rd_data, 8'h00);
      pulse(8'h04, 1'b0);
      chk("R6 underrun sets bit 2", rd_data, 8'h04);
      do_read(v);
      chk("R6 read shared bit", v, 8'h04);
      shared_sel = 1'b0;
      pulse(8'h04, 1'b0);
      chk("R5 qualified abort sets bit 2", rd_data, 8'h04);
      do_read(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_sticky();
      t_collide();
      t_abort_boundary();
      t_shared_select();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule